// File: doc/BRIEF.md
# Serial Shift-Register Output Controller

This block drives a chain of external 8-bit shift registers through three pins: a shift clock, a serial data line and a store strobe that moves the shifted bits to the register outputs. Software programs it through a small register bus. It writes the bit pattern into a data register, enables up to three 8-bit groups, picks the sampling edge of the external parts, and sends a frame by setting the update bit of the first control register.

Eight of the low output bits can be taken from internal hardware status signals instead of software data. Two modem status bits can replace output bits 1:0. A first 3-bit PHY status group can replace bits 4:2, and a second group can replace bits 7:5. Each of these bits has its own enable. The status inputs are sampled when a frame starts, so a prescaler can send frames on its own at one of four rates. This keeps the hardware-driven bits current without software.

The register bus has no handshake. A write takes effect on the clock edge that samples it, a read returns data in the same cycle, and the bus never applies back-pressure. The serial pins are plain outputs with no flow control.

Top module: `shreg_out_ctrl`

## Requirements
- R1: After reset, control word A (offset 0x00) reads 0x8000_0000, and control word B (0x04), data word A (0x08), data word B (0x0C) and the spare word (0x10) read zero. The shift clock is low, and serial data and the store strobe are low. Each word reads back what was last written to it, and an unmapped offset reads zero.
- R2: A frame is requested only by a write to control word A whose bit 31 is 1. A write to any data word, or a write to control word A with bit 31 clear, does not produce a frame.
- R3: The frame length is 24 bits when control word B bit 2 is set, 16 bits when bit 2 is clear and bit 1 is set, 8 bits when only bit 0 is set, and no frame is sent when bits 2:0 are all zero.
- R4: A frame of N bits sends bits N-1 down to 0 of the merged word, most significant first. After the last bit the store strobe is high for exactly one cycle, with the shift clock at its idle level.
- R5: Control word A bit 26 selects the sampling edge: 0 means rising (clock idles low), 1 means falling (clock idles high). Serial data changes only when the clock returns to its idle level, so it is stable for the whole non-idle half-period.
- R6: Control word A bits 25:24 are per-bit enables. When bit 24+k is set, merged bit k comes from modem status input k, for k = 0 and 1.
- R7: Control word A bits 29:27 let PHY group 1 status input k drive merged bit 2+k. Control word B bits 17:15 let PHY group 2 status input k drive merged bit 5+k. All other bits come from data word A.
- R8: A request that arrives during a frame is held and starts one new frame after the store strobe. Any number of requests during one frame collapse into that single extra frame.
- R9: While control word B bit 31 is 1, a frame is requested every CLK_HZ/F cycles. F is 2, 4, 8 or 10 for control word B bits 24:23 = 00, 01, 10 or 11. Clearing bit 31 stops the requests and restarts the period count.
- R10: A software request and an automatic request sampled on the same clock edge give exactly one frame.
- R11: Each half-period of the shift clock lasts CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| mdm_st_i | input | 2 | Modem status bits |
| phy1_st_i | input | 3 | PHY group 1 status bits |
| phy2_st_i | input | 3 | PHY group 2 status bits |
| ser_clk_o | output | 1 | Shift clock to the chain |
| ser_dat_o | output | 1 | Serial data to the chain |
| ser_str_o | output | 1 | Store strobe to the chain |

## Verification
The case that needs care is a software request and an automatic request landing in the same cycle. They must merge into one frame; otherwise one request is lost or an extra frame appears. The bench enables the prescaler at a known edge, which fixes when its first request falls. It then sweeps the software write across the five edges around that point and counts store strobes over a window shorter than two periods. Exactly one frame is expected on the coinciding edge and two on each of the others, and every frame's bits are compared with the merged word.

// File: rtl/shreg_pkg.sv
`timescale 1ns/1ps
package shreg_pkg;
  localparam int NGRP      = 3;
  localparam int GRP_W     = 8;
  localparam int FRAME_W   = NGRP * GRP_W;
  localparam int NBIT_W    = $clog2(FRAME_W + 1);
  localparam int REG_W     = 32;
  localparam int NREG      = 5;
  localparam int HW_W      = 8;

  localparam int IDX_CTLA  = 0;
  localparam int IDX_CTLB  = 1;
  localparam int IDX_DATA  = 2;

  localparam logic [REG_W-1:0] CTLA_RST = 32'h8000_0000;

  localparam int UPD_BIT   = 31;
  localparam int EDGE_BIT  = 26;
  localparam int MDM_LO    = 24;
  localparam int PHYA_LO   = 27;
  localparam int PHYB_LO   = 15;
  localparam int RATE_LO   = 23;
  localparam int AUTO_BIT  = 31;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_LEAD  = 2'd1,
    SH_TRAIL = 2'd2,
    SH_STORE = 2'd3
  } sh_state_e;
endpackage

// File: rtl/shreg_regs.sv
`timescale 1ns/1ps
module shreg_regs
  import shreg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  ctla_o,
  output logic [REG_W-1:0]  ctlb_o,
  output logic [REG_W-1:0]  data_o,
  output logic              sw_req_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [REG_W-1:0] word_q [NREG];

  assign idx = bus_addr[ADDR_W-1:2];
  assign hit = (int'(idx) < NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_word
    localparam logic [REG_W-1:0] RSTV = (g == IDX_CTLA) ? CTLA_RST : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= RSTV;
      end else if (bus_sel && bus_wr && (int'(idx) == g)) begin
        word_q[g] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit && (int'(idx) == i)) bus_rdata = word_q[i];
    end
  end

  assign ctla_o   = word_q[IDX_CTLA];
  assign ctlb_o   = word_q[IDX_CTLB];
  assign data_o   = word_q[IDX_DATA];
  assign sw_req_o = bus_sel && bus_wr && (int'(idx) == IDX_CTLA) && bus_wdata[UPD_BIT];
endmodule

// File: rtl/shreg_merge.sv
`timescale 1ns/1ps
module shreg_merge
  import shreg_pkg::*;
(
  input  logic [FRAME_W-1:0] soft_i,
  input  logic [HW_W-1:0]    hw_sel_i,
  input  logic [HW_W-1:0]    hw_val_i,
  input  logic [NGRP-1:0]    grp_en_i,
  output logic [FRAME_W-1:0] word_o,
  output logic [NBIT_W-1:0]  nbits_o
);
  for (genvar b = 0; b < FRAME_W; b++) begin : g_bit
    if (b < HW_W) begin : g_hw
      assign word_o[b] = hw_sel_i[b] ? hw_val_i[b] : soft_i[b];
    end else begin : g_sw
      assign word_o[b] = soft_i[b];
    end
  end

  always_comb begin
    nbits_o = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_en_i[g]) nbits_o = NBIT_W'((g + 1) * GRP_W);
    end
  end
endmodule

// File: rtl/shreg_rate.sv
`timescale 1ns/1ps
module shreg_rate #(
  parameter int CLK_HZ = 200_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] code_i,
  output logic       tick_o
);
  localparam int LIM2  = CLK_HZ / 2  - 1;
  localparam int LIM4  = CLK_HZ / 4  - 1;
  localparam int LIM8  = CLK_HZ / 8  - 1;
  localparam int LIM10 = CLK_HZ / 10 - 1;
  localparam int CW    = $clog2(LIM2 + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    unique case (code_i)
      2'b00:   lim = CW'(LIM2);
      2'b01:   lim = CW'(LIM4);
      2'b10:   lim = CW'(LIM8);
      default: lim = CW'(LIM10);
    endcase
  end

  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en_i)      cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/shreg_shift.sv
`timescale 1ns/1ps
module shreg_shift
  import shreg_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_req_i,
  input  logic               tick_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic [NBIT_W-1:0]  nbits_i,
  input  logic               fall_i,
  output logic               sclk_o,
  output logic               sdat_o,
  output logic               strobe_o,
  output logic               pend_o
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  sh_state_e          st_q;
  logic               pend_q;
  logic [FRAME_W-1:0] word_q;
  logic [NBIT_W-1:0]  idx_q;
  logic [DIV_W-1:0]   div_q;
  logic               take;

  assign take = (st_q == SH_IDLE) && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q && !take) || sw_req_i || tick_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      word_q <= '0;
      idx_q  <= '0;
      div_q  <= '0;
    end else begin
      unique case (st_q)
        SH_IDLE: begin
          if (take && (nbits_i != '0)) begin
            word_q <= word_i;
            idx_q  <= nbits_i - 1'b1;
            div_q  <= '0;
            st_q   <= SH_LEAD;
          end
        end
        SH_LEAD: begin
          if (div_q == DIV_LAST) begin
            div_q <= '0;
            st_q  <= SH_TRAIL;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        SH_TRAIL: begin
          if (div_q == DIV_LAST) begin
            div_q <= '0;
            if (idx_q == '0) begin
              st_q <= SH_STORE;
            end else begin
              idx_q <= idx_q - 1'b1;
              st_q  <= SH_LEAD;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign sclk_o   = (st_q == SH_TRAIL) ? !fall_i : fall_i;
  assign sdat_o   = ((st_q == SH_LEAD) || (st_q == SH_TRAIL)) ? word_q[idx_q] : 1'b0;
  assign strobe_o = (st_q == SH_STORE);
  assign pend_o   = pend_q;
endmodule

// File: rtl/shreg_out_ctrl.sv
`timescale 1ns/1ps
module shreg_out_ctrl
  import shreg_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        mdm_st_i,
  input  logic [2:0]        phy1_st_i,
  input  logic [2:0]        phy2_st_i,
  output logic              ser_clk_o,
  output logic              ser_dat_o,
  output logic              ser_str_o
);
  logic [REG_W-1:0]   ctla, ctlb, data;
  logic               sw_req, tick, pend, edge_fall;
  logic [HW_W-1:0]    hw_sel, hw_val;
  logic [FRAME_W-1:0] word;
  logic [NBIT_W-1:0]  nbits;

  shreg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctla_o(ctla), .ctlb_o(ctlb), .data_o(data), .sw_req_o(sw_req)
  );

  assign edge_fall = ctla[EDGE_BIT];
  assign hw_sel = {ctlb[PHYB_LO+2:PHYB_LO], ctla[PHYA_LO+2:PHYA_LO], ctla[MDM_LO+1:MDM_LO]};
  assign hw_val = {phy2_st_i, phy1_st_i, mdm_st_i};

  shreg_merge u_merge (
    .soft_i(data[FRAME_W-1:0]), .hw_sel_i(hw_sel), .hw_val_i(hw_val),
    .grp_en_i(ctlb[NGRP-1:0]), .word_o(word), .nbits_o(nbits)
  );

  shreg_rate #(.CLK_HZ(CLK_HZ)) u_rate (
    .clk(clk), .rst_n(rst_n), .en_i(ctlb[AUTO_BIT]),
    .code_i(ctlb[RATE_LO+1:RATE_LO]), .tick_o(tick)
  );

  shreg_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .tick_i(tick),
    .word_i(word), .nbits_i(nbits), .fall_i(edge_fall),
    .sclk_o(ser_clk_o), .sdat_o(ser_dat_o), .strobe_o(ser_str_o), .pend_o(pend)
  );
endmodule

// File: rtl/shreg_out_chk.sv
`timescale 1ns/1ps
module shreg_out_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdat,
  input logic strobe,
  input logic edge_fall,
  input logic sw_req,
  input logic tick,
  input logic pend
);
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  p_strobe_idle_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (sclk == edge_fall));

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sclk != edge_fall) && $past(sclk != edge_fall)) |-> $stable(sdat));

  p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> pend);

  p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind shreg_out_ctrl shreg_out_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(ser_clk_o), .sdat(ser_dat_o),
  .strobe(ser_str_o), .edge_fall(edge_fall), .sw_req(sw_req),
  .tick(tick), .pend(pend)
);

// File: tb/shreg_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module shreg_out_ctrl_tb_top;
  localparam int HZ  = 2000;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  mdm = '0;
  logic [2:0]  p1 = '0, p2 = '0;
  logic        ser_clk, ser_dat, ser_str;

  shreg_out_ctrl #(.CLK_HZ(HZ), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdm_st_i(mdm), .phy1_st_i(p1), .phy2_st_i(p2),
    .ser_clk_o(ser_clk), .ser_dat_o(ser_dat), .ser_str_o(ser_str)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  int n_str = 0, last_str = 0, prev_str = 0;
  bit done = 0, mon_en = 1;
  logic [31:0] m_a = 32'h8000_0000, m_b = 0, m_d = 0;
  logic [23:0] cap = 0;
  int ncap = 0, act_len = 0;
  logic prev_clk = 0, prev_dat = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string what, input longint a, input longint e);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, a, e);
    end
  endtask

  function automatic int exp_n();
    if (m_b[2]) return 24;
    if (m_b[1]) return 16;
    if (m_b[0]) return 8;
    return 0;
  endfunction

  function automatic logic [23:0] exp_word();
    logic [23:0] w = m_d[23:0];
    for (int k = 0; k < 2; k++) if (m_a[24+k]) w[k] = mdm[k];
    for (int k = 0; k < 3; k++) if (m_a[27+k]) w[2+k] = p1[k];
    for (int k = 0; k < 3; k++) if (m_b[15+k]) w[5+k] = p2[k];
    return w & ((24'd1 << exp_n()) - 24'd1);
  endfunction

  // Frame monitor: reference built from bus mirror and status inputs.
  always @(negedge clk) begin
    if (rst_n) begin
      logic act;
      act = m_a[26] ? 1'b0 : 1'b1;
      if (!mon_en) begin
        act_len = 0; cap = 0; ncap = 0;
      end else if (ser_clk == act) begin
        if (prev_clk != act) begin
          cap = {cap[22:0], ser_dat}; ncap++; act_len = 1;
        end else begin
          act_len++;
          chk(ser_dat == prev_dat, "R5 data stable in sampling half", ser_dat, prev_dat);
        end
      end else if (prev_clk == act) begin
        chk(act_len == DIV, "R11 half-period length", act_len, DIV);
        act_len = 0;
      end
      prev_clk = ser_clk;
      prev_dat = ser_dat;
      if (ser_str) begin
        n_str++; prev_str = last_str; last_str = cyc;
        chk(ser_clk == m_a[26], "R4 clock idle at strobe", ser_clk, m_a[26]);
        if (mon_en) begin
          chk(ncap == exp_n(), "R3 frame length", ncap, exp_n());
          chk(cap == exp_word(), "R4 R6 R7 frame bits", cap, exp_word());
        end
        cap = 0; ncap = 0;
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0;
    case (a)
      5'h00: m_a = d;
      5'h04: m_b = d;
      5'h08: m_d = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string what);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(bus_rdata == e, what, bus_rdata, e);
    bus_sel = 0;
  endtask

  task automatic wait_str(input int target, input int tmo);
    for (int i = 0; i < tmo && n_str < target; i++) @(posedge clk);
  endtask

  task automatic frame(input string what);
    int s0 = n_str;
    wr(5'h00, m_a | 32'h8000_0000);
    wait_str(s0 + 1, 400);
    repeat (20) @(posedge clk);
    chk(n_str == s0 + 1, what, n_str - s0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ser_clk == 0 && ser_dat == 0 && ser_str == 0, "R1 serial pins at reset",
        {ser_clk, ser_dat, ser_str}, 0);
    rd_chk(5'h00, 32'h8000_0000, "R1 control A reset");
    rd_chk(5'h04, 0, "R1 control B reset");
    rd_chk(5'h08, 0, "R1 data A reset");
    rd_chk(5'h0C, 0, "R1 data B reset");
    rd_chk(5'h10, 0, "R1 spare reset");
    wr(5'h0C, 32'h1234_5678); rd_chk(5'h0C, 32'h1234_5678, "R1 data B readback");
    wr(5'h10, 32'hCAFE_0001); rd_chk(5'h10, 32'hCAFE_0001, "R1 spare readback");
    rd_chk(5'h14, 0, "R1 unmapped offset");

    // R2 only control A with bit 31 starts a frame
    s0 = n_str;
    wr(5'h04, 32'h0000_0001);
    wr(5'h08, 32'h00A5_C396);
    wr(5'h00, 32'h0000_0000);
    repeat (100) @(posedge clk);
    chk(n_str == s0, "R2 no frame without update bit", n_str - s0, 0);
    frame("R2 update bit sends one frame");

    // R3 frame lengths per group enable
    wr(5'h04, 32'h0000_0003); frame("R3 16-bit frame");
    wr(5'h04, 32'h0000_0004); frame("R3 24-bit frame top group only");
    wr(5'h04, 32'h0000_0002); wr(5'h08, 32'h005A_3C69); frame("R3 16-bit frame group 1 only");
    wr(5'h04, 32'h0000_0000);
    s0 = n_str;
    wr(5'h00, 32'h8000_0000);
    repeat (150) @(posedge clk);
    chk(n_str == s0, "R3 no frame with no group", n_str - s0, 0);
    chk(ser_clk == 0, "R3 clock idle with no group", ser_clk, 0);

    // R5 falling-edge mode
    mon_en = 0;
    wr(5'h00, 32'h0400_0000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ser_clk == 1, "R5 clock idles high in falling mode", ser_clk, 1);
    prev_clk = 1;
    mon_en = 1;
    wr(5'h04, 32'h0000_0007); frame("R5 frame in falling mode");

    // R6 modem override, R7 PHY override
    mdm = 2'b10; p1 = 3'b011; p2 = 3'b101;
    wr(5'h08, 32'h0000_00FF);
    wr(5'h00, 32'h0300_0000 | 32'h0400_0000); frame("R6 modem bits replace bits 1:0");
    wr(5'h08, 32'h0000_0000);
    wr(5'h00, 32'h2800_0000 | 32'h0400_0000);
    wr(5'h04, 32'h0001_4001); frame("R7 phy groups replace selected bits");
    mdm = 2'b01; p1 = 3'b110; p2 = 3'b010;
    wr(5'h00, 32'h3F00_0000 | 32'h0400_0000);
    wr(5'h04, 32'h0003_8007); frame("R6 R7 all status bits enabled");

    // back to rising mode, plain data
    mon_en = 0;
    wr(5'h00, 32'h0000_0000);
    repeat (3) @(posedge clk);
    @(negedge clk); prev_clk = 0;
    mon_en = 1;
    wr(5'h08, 32'h00C3_5A0F);
    wr(5'h04, 32'h0000_0007);

    // R8 requests during a frame collapse into one extra frame
    s0 = n_str;
    wr(5'h00, 32'h8000_0000);
    repeat (30) @(posedge clk);
    wr(5'h00, 32'h8000_0000);
    repeat (10) @(posedge clk);
    wr(5'h00, 32'h8000_0000);
    wait_str(s0 + 2, 800);
    repeat (200) @(posedge clk);
    chk(n_str == s0 + 2, "R8 held request gives one extra frame", n_str - s0, 2);

    // R9 automatic update rates
    for (int c = 0; c < 4; c++) begin
      int per, i1, i2;
      per = (c == 0) ? HZ / 2 : (c == 1) ? HZ / 4 : (c == 2) ? HZ / 8 : HZ / 10;
      wr(5'h04, 32'h0000_0001);
      repeat (80) @(posedge clk);
      s0 = n_str;
      wr(5'h04, 32'h8000_0001 | (32'(c) << 23));
      wait_str(s0 + 2, 4 * per);
      i1 = last_str - prev_str;
      wait_str(s0 + 3, 4 * per);
      i2 = last_str - prev_str;
      chk(n_str >= s0 + 3 && i1 == per && i2 == per, $sformatf("R9 period rate code %0d", c), i2, per);
    end
    wr(5'h04, 32'h0000_0001);
    repeat (80) @(posedge clk);

    // R10 software write swept around the first automatic request
    for (int d = HZ / 10 - 2; d <= HZ / 10 + 2; d++) begin
      int got, want;
      s0 = n_str;
      wr(5'h04, 32'h8180_0001);
      repeat (d - 1) @(posedge clk);
      wr(5'h00, 32'h8000_0000);
      repeat (HZ / 10 + 150 - d) @(posedge clk);
      got = n_str - s0;
      want = (d == HZ / 10) ? 1 : 2;
      chk(got == want, $sformatf("R10 frames for offset %0d", d), got, want);
      wr(5'h04, 32'h0180_0001);
      repeat (80) @(posedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule